// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block sits on the primary side of a PCI-to-PCI bridge. For each transaction it decides whether the address falls inside one of the bridge's three forwarding windows: I/O, non-prefetchable memory and prefetchable memory. The windows are built from the raw base and limit register contents, which the block takes as plain inputs. Each register's low-order type code decides whether the upper address bits take part. The command-register I/O-enable and memory-enable bits gate the windows.

Requests arrive on a valid/ready stream that carries an address and a transaction kind. Each accepted request produces one registered result one cycle later, on a second valid/ready stream. The result holds the three per-window hit flags and a combined forward flag. It also holds the base, inclusive limit and byte size of the window that applies to the request.

The output stage holds one result. A new request is accepted only when that stage is empty or is being drained in the same cycle. While the consumer holds `rsp_ready` low, the result stays frozen and no new request is taken in.

Top module: `bridge_window_decoder`

## Requirements
- R1: I/O window. Bits 15:12 of the base come from bits 7:4 of the I/O base byte. Bits 31:16 come from the 16-bit upper I/O base register when bit 0 of the base byte is 1 (32-bit addressing); otherwise they are zero. The limit is built the same way from its own byte and upper register, with bits 11:0 forced to ones.
- R2: Non-prefetchable memory window. Bits 31:20 of the base come from bits 15:4 of the 16-bit memory base register, and all other bits are zero. The limit is built the same way, with bits 19:0 forced to ones.
- R3: Prefetchable memory window. It uses the R2 layout. In addition, bits 63:32 come from the 32-bit upper register when bit 0 of the matching 16-bit register is 1 (64-bit addressing); otherwise they are zero. Base and limit each use their own type bit.
- R4: A window whose limit is below its base never matches, and its reported size is zero.
- R5: The I/O window can match only while `io_en` is 1. Both memory windows can match only while `mem_en` is 1. The enable values used are those present when the request is accepted.
- R6: When an address lies in both memory windows, only `hit_pmem` is set. At most one hit flag is ever set.
- R7: `req_kind` encoding: 2'b00 is I/O, 2'b01 is memory, 2'b10 is prefetchable memory and 2'b11 is reserved. I/O requests check only the I/O window. Both memory kinds check both memory windows in the same way. Reserved requests hit nothing, and their base, limit and size are zero.
- R8: `fwd` is 1 exactly when one of the hit flags is 1.
- R9: A request accepted at a clock edge gives `rsp_valid` = 1 after that edge. The result reports the window that applies:
  - an I/O request reports the I/O window;
  - a memory request reports the prefetchable window if it hit, and the plain memory window otherwise.
- R10: `req_ready` is 1 when no result is pending or when `rsp_ready` is 1. While `rsp_valid` is 1 and `rsp_ready` is 0, every result output holds its value.
- R11: After reset, `rsp_valid` is 0 and `req_ready` is 1.
- R12: `win_size` is limit + 1 − base in 65 bits for a non-empty window. A window that spans the whole 64-bit space therefore reports 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_en | input | 1 | Command-register I/O enable |
| mem_en | input | 1 | Command-register memory enable |
| io_base_reg | input | 8 | Raw I/O base byte (bits 7:4 address, bit 0 type) |
| io_limit_reg | input | 8 | Raw I/O limit byte (bits 7:4 address, bit 0 type) |
| io_base_upper | input | 16 | Upper 16 bits of the I/O base |
| io_limit_upper | input | 16 | Upper 16 bits of the I/O limit |
| mem_base_reg | input | 16 | Raw memory base (bits 15:4 address) |
| mem_limit_reg | input | 16 | Raw memory limit (bits 15:4 address) |
| pmem_base_reg | input | 16 | Raw prefetchable base (bits 15:4 address, bit 0 type) |
| pmem_limit_reg | input | 16 | Raw prefetchable limit (bits 15:4 address, bit 0 type) |
| pmem_base_upper | input | 32 | Upper 32 bits of the prefetchable base |
| pmem_limit_upper | input | 32 | Upper 32 bits of the prefetchable limit |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_kind | input | 2 | Transaction kind (R7) |
| req_addr | input | 64 | Transaction address |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| hit_io | output | 1 | Address inside the I/O window |
| hit_mem | output | 1 | Address inside the non-prefetchable window |
| hit_pmem | output | 1 | Address inside the prefetchable window |
| fwd | output | 1 | Transaction is forwarded |
| win_base | output | 64 | Base of the reported window |
| win_limit | output | 64 | Inclusive limit of the reported window |
| win_size | output | 65 | Size of the reported window |

## Verification
Each request yields exactly one result, so any fault in window expansion or comparison shows up in that result. A wrong type-bit decode or granularity fill appears in `win_base` or `win_limit`. A comparison or enable fault flips a hit flag. Either shows up on the very next `rsp_valid` beat for a request placed at the affected window edge. Faults in the output register show up differently. A lost or duplicated result, or a value that drifts during a stall, breaks the in-order pairing of results with requests, and this is seen at the first beat after the faulty cycle. For that reason the stimulus places addresses one byte inside and one byte outside each boundary, and throttles `rsp_ready` throughout.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam int ADDR_W    = 64;
  localparam int SIZE_W    = ADDR_W + 1;
  localparam int LO_W      = 16;
  localparam int HI_W      = 32;
  localparam int IO_GRAN   = 12;
  localparam int MEM_GRAN  = 20;
  localparam int IO_UP_W   = 16;
  localparam int NUM_WIN   = 3;

  localparam int WIN_IO   = 0;
  localparam int WIN_MEM  = 1;
  localparam int WIN_PMEM = 2;

  typedef enum logic [1:0] {
    KIND_IO   = 2'b00,
    KIND_MEM  = 2'b01,
    KIND_PMEM = 2'b10,
    KIND_RSVD = 2'b11
  } txn_kind_e;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
    logic [SIZE_W-1:0] size;
    logic              empty;
  } window_t;
endpackage

// File: rtl/bwd_window_expand.sv
module bwd_window_expand
  import bwd_pkg::*;
#(
  parameter int WIN = WIN_IO
) (
  input  logic [LO_W-1:0] base_lo,
  input  logic [LO_W-1:0] limit_lo,
  input  logic [HI_W-1:0] base_hi,
  input  logic [HI_W-1:0] limit_hi,
  output window_t         win
);
  logic [ADDR_W-1:0] base_w;
  logic [ADDR_W-1:0] limit_w;
  logic              unused_raw;

  assign unused_raw = ^{base_lo, limit_lo, base_hi, limit_hi};

  generate
    if (WIN == WIN_IO) begin : g_io
      // 4 KB granularity, optional 32-bit extension from the upper register
      assign base_w  = {{(ADDR_W-32){1'b0}},
                        (base_lo[0]  ? base_hi[IO_UP_W-1:0]  : {IO_UP_W{1'b0}}),
                        base_lo[7:4], {IO_GRAN{1'b0}}};
      assign limit_w = {{(ADDR_W-32){1'b0}},
                        (limit_lo[0] ? limit_hi[IO_UP_W-1:0] : {IO_UP_W{1'b0}}),
                        limit_lo[7:4], {IO_GRAN{1'b1}}};
    end else if (WIN == WIN_MEM) begin : g_mem
      // 1 MB granularity, 32-bit only
      assign base_w  = {{(ADDR_W-32){1'b0}}, base_lo[LO_W-1:4],  {MEM_GRAN{1'b0}}};
      assign limit_w = {{(ADDR_W-32){1'b0}}, limit_lo[LO_W-1:4], {MEM_GRAN{1'b1}}};
    end else begin : g_pmem
      // 1 MB granularity, optional 64-bit extension
      assign base_w  = {(base_lo[0]  ? base_hi  : {HI_W{1'b0}}),
                        base_lo[LO_W-1:4],  {MEM_GRAN{1'b0}}};
      assign limit_w = {(limit_lo[0] ? limit_hi : {HI_W{1'b0}}),
                        limit_lo[LO_W-1:4], {MEM_GRAN{1'b1}}};
    end
  endgenerate

  always_comb begin
    win.base  = base_w;
    win.limit = limit_w;
    win.empty = (limit_w < base_w);
    if (win.empty) win.size = '0;
    else           win.size = {1'b0, limit_w} + {{ADDR_W{1'b0}}, 1'b1} - {1'b0, base_w};
  end
endmodule

// File: rtl/bwd_range_match.sv
module bwd_range_match
  import bwd_pkg::*;
(
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  input  logic              empty,
  input  logic              enable,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic above_base;
  logic below_limit;

  assign above_base  = (addr >= base);
  assign below_limit = (addr <= limit);
  assign hit         = enable && !empty && above_base && below_limit;
endmodule

// File: rtl/bridge_window_decoder.sv
module bridge_window_decoder
  import bwd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               io_en,
  input  logic               mem_en,
  input  logic [7:0]         io_base_reg,
  input  logic [7:0]         io_limit_reg,
  input  logic [15:0]        io_base_upper,
  input  logic [15:0]        io_limit_upper,
  input  logic [15:0]        mem_base_reg,
  input  logic [15:0]        mem_limit_reg,
  input  logic [15:0]        pmem_base_reg,
  input  logic [15:0]        pmem_limit_reg,
  input  logic [31:0]        pmem_base_upper,
  input  logic [31:0]        pmem_limit_upper,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_kind,
  input  logic [63:0]        req_addr,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               hit_io,
  output logic               hit_mem,
  output logic               hit_pmem,
  output logic               fwd,
  output logic [63:0]        win_base,
  output logic [63:0]        win_limit,
  output logic [64:0]        win_size
);
  logic [LO_W-1:0]    lo_b   [NUM_WIN];
  logic [LO_W-1:0]    lo_l   [NUM_WIN];
  logic [HI_W-1:0]    hi_b   [NUM_WIN];
  logic [HI_W-1:0]    hi_l   [NUM_WIN];
  logic               win_en [NUM_WIN];
  window_t            win    [NUM_WIN];
  logic [NUM_WIN-1:0] in_range;

  // raw register routing per window
  assign lo_b[WIN_IO]   = {8'h00, io_base_reg};
  assign lo_l[WIN_IO]   = {8'h00, io_limit_reg};
  assign hi_b[WIN_IO]   = {16'h0000, io_base_upper};
  assign hi_l[WIN_IO]   = {16'h0000, io_limit_upper};
  assign lo_b[WIN_MEM]  = mem_base_reg;
  assign lo_l[WIN_MEM]  = mem_limit_reg;
  assign hi_b[WIN_MEM]  = '0;
  assign hi_l[WIN_MEM]  = '0;
  assign lo_b[WIN_PMEM] = pmem_base_reg;
  assign lo_l[WIN_PMEM] = pmem_limit_reg;
  assign hi_b[WIN_PMEM] = pmem_base_upper;
  assign hi_l[WIN_PMEM] = pmem_limit_upper;

  assign win_en[WIN_IO]   = io_en;
  assign win_en[WIN_MEM]  = mem_en;
  assign win_en[WIN_PMEM] = mem_en;

  generate
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      bwd_window_expand #(.WIN(w)) u_expand (
        .base_lo  (lo_b[w]),
        .limit_lo (lo_l[w]),
        .base_hi  (hi_b[w]),
        .limit_hi (hi_l[w]),
        .win      (win[w])
      );
      bwd_range_match u_match (
        .base   (win[w].base),
        .limit  (win[w].limit),
        .empty  (win[w].empty),
        .enable (win_en[w]),
        .addr   (req_addr),
        .hit    (in_range[w])
      );
    end
  endgenerate

  // kind decode, priority and window selection
  txn_kind_e kind;
  logic      is_io;
  logic      is_mem;
  logic      nxt_io;
  logic      nxt_mem;
  logic      nxt_pmem;
  window_t   sel;
  logic      unused_sel;

  always_comb begin
    kind     = txn_kind_e'(req_kind);
    is_io    = (kind == KIND_IO);
    is_mem   = (kind == KIND_MEM) || (kind == KIND_PMEM);
    nxt_io   = in_range[WIN_IO] && is_io;
    nxt_pmem = in_range[WIN_PMEM] && is_mem;
    nxt_mem  = in_range[WIN_MEM] && is_mem && !in_range[WIN_PMEM];
    sel      = '0;
    if (is_io)       sel = win[WIN_IO];
    else if (is_mem) sel = in_range[WIN_PMEM] ? win[WIN_PMEM] : win[WIN_MEM];
  end

  assign unused_sel = sel.empty;

  // single-entry output stage
  logic accept;
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      hit_io    <= 1'b0;
      hit_mem   <= 1'b0;
      hit_pmem  <= 1'b0;
      fwd       <= 1'b0;
      win_base  <= '0;
      win_limit <= '0;
      win_size  <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      hit_io    <= nxt_io;
      hit_mem   <= nxt_mem;
      hit_pmem  <= nxt_pmem;
      fwd       <= nxt_io || nxt_mem || nxt_pmem;
      win_base  <= sel.base;
      win_limit <= sel.limit;
      win_size  <= sel.size;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bwd_checker.sv
module bwd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        io_en,
  input logic        mem_en,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic        hit_io,
  input logic        hit_mem,
  input logic        hit_pmem,
  input logic        fwd,
  input logic [63:0] win_base,
  input logic [63:0] win_limit,
  input logic [64:0] win_size
);
  // R10
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(win_base) && $stable(win_limit)
      && $stable(win_size) && $stable({hit_io, hit_mem, hit_pmem, fwd})));

  // R9
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R6
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot0({hit_io, hit_mem, hit_pmem}));

  // R8
  fwd_matches_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (fwd == (hit_io || hit_mem || hit_pmem)));

  // R5
  io_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !io_en) |=> !hit_io);

  // R5
  mem_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !mem_en) |=> (!hit_mem && !hit_pmem));

  // R11
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !rsp_valid);
endmodule

bind bridge_window_decoder bwd_checker u_bwd_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .io_en     (io_en),
  .mem_en    (mem_en),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .hit_io    (hit_io),
  .hit_mem   (hit_mem),
  .hit_pmem  (hit_pmem),
  .fwd       (fwd),
  .win_base  (win_base),
  .win_limit (win_limit),
  .win_size  (win_size)
);

// File: tb/bridge_window_decoder_tb.sv
module bridge_window_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_en = 1'b0, mem_en = 1'b0;
  logic [7:0]  io_base_reg = '0, io_limit_reg = '0;
  logic [15:0] io_base_upper = '0, io_limit_upper = '0;
  logic [15:0] mem_base_reg = '0, mem_limit_reg = '0;
  logic [15:0] pmem_base_reg = '0, pmem_limit_reg = '0;
  logic [31:0] pmem_base_upper = '0, pmem_limit_upper = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = '0;
  logic [63:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        hit_io, hit_mem, hit_pmem, fwd;
  logic [63:0] win_base, win_limit;
  logic [64:0] win_size;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit throttle = 1'b0;

  always #2 clk = ~clk;

  bridge_window_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .io_en(io_en), .mem_en(mem_en),
    .io_base_reg(io_base_reg), .io_limit_reg(io_limit_reg),
    .io_base_upper(io_base_upper), .io_limit_upper(io_limit_upper),
    .mem_base_reg(mem_base_reg), .mem_limit_reg(mem_limit_reg),
    .pmem_base_reg(pmem_base_reg), .pmem_limit_reg(pmem_limit_reg),
    .pmem_base_upper(pmem_base_upper), .pmem_limit_upper(pmem_limit_upper),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .hit_io(hit_io), .hit_mem(hit_mem), .hit_pmem(hit_pmem), .fwd(fwd),
    .win_base(win_base), .win_limit(win_limit), .win_size(win_size)
  );

  typedef struct {
    string       tag;
    logic [2:0]  hits;
    logic        fwd;
    logic [63:0] base;
    logic [63:0] limit;
    logic [64:0] size;
  } exp_t;

  exp_t sb[$];

  function automatic logic [63:0] io_edge(input logic [7:0] r, input logic [15:0] up, input bit lim);
    return {32'h0, (r[0] ? up : 16'h0), r[7:4], (lim ? 12'hFFF : 12'h000)};
  endfunction
  function automatic logic [63:0] mem_edge(input logic [15:0] r, input bit lim);
    return {32'h0, r[15:4], (lim ? 20'hFFFFF : 20'h00000)};
  endfunction
  function automatic logic [63:0] pmem_edge(input logic [15:0] r, input logic [31:0] up, input bit lim);
    return {(r[0] ? up : 32'h0), r[15:4], (lim ? 20'hFFFFF : 20'h00000)};
  endfunction
  function automatic logic [64:0] span(input logic [63:0] b, input logic [63:0] l);
    if (l < b) return '0;
    return {1'b0, l} - {1'b0, b} + 65'd1;
  endfunction

  task automatic check(input string tag, input bit ok, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: issue one request, push its expected result on acceptance
  task automatic send(input logic [1:0] kind, input logic [63:0] addr, input string tag);
    exp_t e;
    logic [63:0] ib, il, mb, ml, pb, pl;
    bit in_io, in_mem, in_pm;
    @(negedge clk);
    req_kind  = kind;
    req_addr  = addr;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    ib = io_edge(io_base_reg, io_base_upper, 0);
    il = io_edge(io_limit_reg, io_limit_upper, 1);
    mb = mem_edge(mem_base_reg, 0);
    ml = mem_edge(mem_limit_reg, 1);
    pb = pmem_edge(pmem_base_reg, pmem_base_upper, 0);
    pl = pmem_edge(pmem_limit_reg, pmem_limit_upper, 1);
    in_io  = io_en  && addr >= ib && addr <= il;
    in_mem = mem_en && addr >= mb && addr <= ml;
    in_pm  = mem_en && addr >= pb && addr <= pl;
    e.tag = tag;
    e.hits = 3'b000; e.base = '0; e.limit = '0; e.size = '0;
    if (kind == 2'b00) begin
      e.hits = {1'b0, 1'b0, in_io};
      e.base = ib; e.limit = il; e.size = span(ib, il);
    end else if (kind == 2'b01 || kind == 2'b10) begin
      if (in_pm) begin
        e.hits = 3'b100; e.base = pb; e.limit = pl; e.size = span(pb, pl);
      end else begin
        e.hits = {1'b0, in_mem, 1'b0}; e.base = mb; e.limit = ml; e.size = span(mb, ml);
      end
    end
    e.fwd = |e.hits;
    sb.push_back(e);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  // monitor: compare each result as it is consumed
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_valid && rsp_ready) begin
        if (sb.size() == 0) begin
          check("R9 unexpected result", 1'b0, 128'd1, 128'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({e.tag, " hits"}, {hit_pmem, hit_mem, hit_io} == e.hits,
                {125'd0, hit_pmem, hit_mem, hit_io}, {125'd0, e.hits});
          check({e.tag, " R8 fwd"}, fwd == e.fwd, {127'd0, fwd}, {127'd0, e.fwd});
          check({e.tag, " base"}, win_base == e.base, {64'd0, win_base}, {64'd0, e.base});
          check({e.tag, " limit"}, win_limit == e.limit, {64'd0, win_limit}, {64'd0, e.limit});
          check({e.tag, " R12 size"}, win_size == e.size, {63'd0, win_size}, {63'd0, e.size});
        end
      end
    end
  end

  // consumer back-pressure pattern
  initial begin
    int c = 0;
    forever begin
      @(posedge clk);
      #1;
      c++;
      rsp_ready = throttle ? ((c % 3) != 1) : 1'b1;
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    check("R11 rsp_valid after reset", rsp_valid == 1'b0, {127'd0, rsp_valid}, 128'd0);
    check("R11 req_ready after reset", req_ready == 1'b1, {127'd0, req_ready}, 128'd1);
    rst_n = 1'b1;

    // R1 16-bit I/O window 0x2000..0x3FFF
    io_en = 1'b1; mem_en = 1'b1;
    io_base_reg = 8'h20; io_limit_reg = 8'h30;
    io_base_upper = 16'h0005; io_limit_upper = 16'h0005;
    send(2'b00, 64'h2800, "R1 io inside");
    send(2'b00, 64'h3FFF, "R1 io last byte");
    send(2'b00, 64'h4000, "R1 io past limit");
    send(2'b00, 64'h1FFF, "R1 io below base");
    // R1 32-bit I/O window 0x12000..0x12FFF
    io_base_reg = 8'h21; io_limit_reg = 8'h21;
    io_base_upper = 16'h0001; io_limit_upper = 16'h0001;
    send(2'b00, 64'h12ABC, "R1 io32 inside");
    send(2'b00, 64'h02ABC, "R1 io32 upper mismatch");
    // R5 I/O disabled
    io_en = 1'b0;
    send(2'b00, 64'h12000, "R5 io disabled");
    io_en = 1'b1;
    // R7 I/O request does not see memory windows
    mem_base_reg = 16'h1230; mem_limit_reg = 16'h1240;
    send(2'b00, 64'h12400000, "R7 io kind vs memory address");

    // R2 memory window 0x12300000..0x124FFFFF
    send(2'b01, 64'h12400000, "R2 mem inside");
    send(2'b01, 64'h124FFFFF, "R2 mem last byte");
    send(2'b01, 64'h12500000, "R2 mem past limit");
    send(2'b01, 64'h1_12400000, "R2 mem above 4G");

    // R3 64-bit prefetchable window 0x2_00000000..0x2_FFFFFFFF
    pmem_base_reg = 16'h0001; pmem_base_upper = 32'h2;
    pmem_limit_reg = 16'hFFF1; pmem_limit_upper = 32'h2;
    send(2'b10, 64'h2_10000000, "R3 pmem64 inside");
    send(2'b10, 64'h3_00000000, "R3 pmem64 past limit");

    // R6 overlap, prefetchable wins; R7 both memory kinds agree
    pmem_base_reg = 16'h1200; pmem_limit_reg = 16'h12F0;
    throttle = 1'b1;
    send(2'b01, 64'h12350000, "R6 overlap mem kind");
    send(2'b10, 64'h12350000, "R6 R7 overlap pmem kind");
    send(2'b10, 64'h12250000, "R6 pmem only");

    // R4 empty memory window
    mem_base_reg = 16'h2000; mem_limit_reg = 16'h1000;
    send(2'b01, 64'h18000000, "R4 empty window");
    // R5 memory disabled
    mem_base_reg = 16'h1230; mem_limit_reg = 16'h1240;
    mem_en = 1'b0;
    send(2'b01, 64'h12400000, "R5 mem disabled");
    send(2'b10, 64'h12250000, "R5 pmem disabled");
    mem_en = 1'b1;

    // R7 reserved kind
    send(2'b11, 64'h12400000, "R7 reserved kind");

    // R12 whole 64-bit prefetchable window
    pmem_base_reg = 16'h0001; pmem_base_upper = 32'h0;
    pmem_limit_reg = 16'hFFF1; pmem_limit_upper = 32'hFFFFFFFF;
    send(2'b10, 64'hFFFFFFFF_FFFFFFFF, "R12 full window");

    // R10 back-to-back stream under throttling
    for (int i = 0; i < 8; i++) begin
      send(2'b01, 64'h1000_0000 * i, "R10 stream");
    end

    throttle = 1'b0;
    repeat (10) @(negedge clk);
    check("R9 all results delivered", sb.size() == 0, 128'(sb.size()), 128'd0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule